// File: doc/BRIEF.md
# Configuration Register Access Gate

This block sits between a host I/O port and three 8-bit configuration registers (called A, B and C here). It decides, access by access, whether a host write to one of those registers is allowed to land. Writes are accepted only after a specific run of reads, so stray writes from unrelated software cannot reconfigure the part. One bit of register C can shut off software writes entirely. Every host access, read or write, anywhere in I/O space, is seen by the block. Each access either extends or breaks the unlock history.

A second path lets configuration software place the I/O base without knowing it in advance. While no base has been assigned, a fixed port address (default 278h) accepts a run of consecutive writes. The last write of the run copies the low three data bits into the I/O-address field of register A. That path then closes until the next reset, and a flag reports the assignment.

The registers are reached only while the page-select input is high. Reads return the addressed register on the data output in the same cycle. Reserved bits are held at fixed values whatever the host writes.

Top module: `cfg_access_gate`

## Requirements
- R1: A write to register A (address `ADDR_A`, page selected) changes A only if the immediately preceding host access was a read of A; cycles with neither strobe are not accesses and do not break the history.
- R2: A write to register B (address `ADDR_B`, page selected) changes B only if the immediately preceding host access was a read of B.
- R3: A write to register C (address `ADDR_C`, page selected) changes C only if it directly follows at least `C_UNLOCK_READS` (default 3) consecutive reads of A.
- R4: While bit 7 of C is 1, no host write changes A, B or C; the I/O-base assignment path of R6 is not affected by this bit.
- R5: Every host access other than a read of A or of B clears the unlock history, including writes whether accepted or dropped, reads of C and accesses to any other address or with the page deselected.
- R6: While the base is unassigned, the `JL_WRITES`-th (default 4) consecutive write to `PORT_ADDR` (default 278h) copies data bits 2..0 into A bits 2..0, leaves A bits 7..3 unchanged and raises `base_assigned`; any other access in between restarts the count.
- R7: Once `base_assigned` is 1 it stays 1 and writes to `PORT_ADDR` have no effect until reset.
- R8: Reserved bits are forced at reset and on every write: A bit 7 = 0, B bit 4 = 0, C bits 6..4 = 0,1,0.
- R9: After reset A = `RST_A` (default 00h), B = `RST_B` (default 00h), C = `RST_C` with reserved bits applied (default 20h), and `base_assigned` = 0.
- R10: During a read of A, B or C with page selected, `rdata` shows that register in the same cycle; in every other cycle `rdata` is 00h.
- R11: A cycle with both strobes high is a read only; it writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| io_addr | input | ADDR_W | Host I/O address |
| io_wdata | input | 8 | Host write data |
| io_rd | input | 1 | Host read strobe, one cycle per access |
| io_wr | input | 1 | Host write strobe, one cycle per access |
| page_sel | input | 1 | High when the configuration page is selected |
| rdata | output | 8 | Read data for the addressed register |
| cfg_a | output | 8 | Register A |
| cfg_b | output | 8 | Register B |
| cfg_c | output | 8 | Register C |
| base_assigned | output | 1 | I/O base has been assigned through the port path |

## Verification
The bench builds the block with its default parameters, which means three reads unlock C and four port writes assign the base. Those small counts let random traffic of a few thousand accesses reach both the C unlock and the base assignment many times. The mix of addresses is weighted toward A and the port so that these runs actually form. Periodic resets reopen the one-shot port path. The lock bit is set only rarely, so most of the traffic still exercises the unlock rules.

// File: rtl/cfg_gate_pkg.sv
// Shared types and reserved-bit handling for the configuration access gate.
// Assumes 8-bit configuration registers with fixed reserved-bit positions.
package cfg_gate_pkg;

    // One host access, classified once and consumed by every tracker.
    typedef enum logic [3:0] {
        ACC_IDLE,
        ACC_RD_A,
        ACC_RD_B,
        ACC_RD_C,
        ACC_RD_OTHER,
        ACC_WR_A,
        ACC_WR_B,
        ACC_WR_C,
        ACC_WR_PORT,
        ACC_WR_OTHER
    } acc_kind_e;

    localparam int unsigned REG_W     = 8;
    localparam int unsigned BASE_W    = 3;
    localparam logic [7:0]  A_KEEP    = 8'h7F;
    localparam logic [7:0]  B_KEEP    = 8'hEF;
    localparam logic [7:0]  C_KEEP    = 8'h8F;
    localparam logic [7:0]  C_FORCE   = 8'h20;
    localparam int unsigned LOCK_BIT  = 7;

    function automatic logic [7:0] fix_a(input logic [7:0] d);
        return d & A_KEEP;
    endfunction

    function automatic logic [7:0] fix_b(input logic [7:0] d);
        return d & B_KEEP;
    endfunction

    function automatic logic [7:0] fix_c(input logic [7:0] d);
        return (d & C_KEEP) | C_FORCE;
    endfunction

endpackage

// File: rtl/cfg_acc_decode.sv
// Classifies the current host cycle into one access kind.
// Assumes at most one access per cycle; a read strobe wins over a write strobe.
module cfg_acc_decode
    import cfg_gate_pkg::*;
#(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ADDR_A    = 'h300,
    parameter int unsigned ADDR_B    = 'h301,
    parameter int unsigned ADDR_C    = 'h302,
    parameter int unsigned PORT_ADDR = 'h278
) (
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              page_sel,
    output acc_kind_e         kind
);

    logic is_rd;
    logic is_wr;
    logic hit_a;
    logic hit_b;
    logic hit_c;
    logic hit_port;

    // Address matches; register hits need the page selected.
    always_comb begin
        is_rd    = io_rd;
        is_wr    = io_wr & ~io_rd;
        hit_a    = page_sel && (io_addr == ADDR_W'(ADDR_A));
        hit_b    = page_sel && (io_addr == ADDR_W'(ADDR_B));
        hit_c    = page_sel && (io_addr == ADDR_W'(ADDR_C));
        hit_port = (io_addr == ADDR_W'(PORT_ADDR));
    end

    // Encode the access kind from strobe and address.
    always_comb begin
        kind = ACC_IDLE;
        if (is_rd) begin
            if (hit_a)      kind = ACC_RD_A;
            else if (hit_b) kind = ACC_RD_B;
            else if (hit_c) kind = ACC_RD_C;
            else            kind = ACC_RD_OTHER;
        end else if (is_wr) begin
            if (hit_a)         kind = ACC_WR_A;
            else if (hit_b)    kind = ACC_WR_B;
            else if (hit_c)    kind = ACC_WR_C;
            else if (hit_port) kind = ACC_WR_PORT;
            else               kind = ACC_WR_OTHER;
        end
    end

endmodule

// File: rtl/cfg_unlock_track.sv
// Keeps the read history that unlocks writes to A, B and C.
// Assumes idle cycles carry no access and leave the history untouched.
module cfg_unlock_track
    import cfg_gate_pkg::*;
#(
    parameter int unsigned C_UNLOCK_READS = 3
) (
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_e kind,
    output logic      ok_a,
    output logic      ok_b,
    output logic      ok_c
);

    localparam int unsigned RUN_W   = $clog2(C_UNLOCK_READS + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(C_UNLOCK_READS);

    logic [RUN_W-1:0] rd_a_run;
    logic             prev_rd_b;

    // Count consecutive reads of A (saturating) and remember a read of B.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_a_run  <= '0;
            prev_rd_b <= 1'b0;
        end else begin
            case (kind)
                ACC_IDLE: ;
                ACC_RD_A: begin
                    rd_a_run  <= (rd_a_run == RUN_MAX) ? RUN_MAX : rd_a_run + RUN_W'(1);
                    prev_rd_b <= 1'b0;
                end
                ACC_RD_B: begin
                    rd_a_run  <= '0;
                    prev_rd_b <= 1'b1;
                end
                default: begin
                    rd_a_run  <= '0;
                    prev_rd_b <= 1'b0;
                end
            endcase
        end
    end

    // Unlock conditions seen by the current cycle's write.
    always_comb begin
        ok_a = (rd_a_run != '0);
        ok_b = prev_rd_b;
        ok_c = (rd_a_run == RUN_MAX);
    end

endmodule

// File: rtl/cfg_base_assign.sv
// One-shot I/O-base assignment through a run of writes to a fixed port.
// Assumes JL_WRITES is at least 2; the path reopens only on reset.
module cfg_base_assign
    import cfg_gate_pkg::*;
#(
    parameter int unsigned JL_WRITES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  acc_kind_e kind,
    output logic      load_base,
    output logic      base_assigned
);

    localparam int unsigned CNT_W = $clog2(JL_WRITES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(JL_WRITES - 1);

    logic [CNT_W-1:0] port_run;
    logic             port_wr_open;

    // A port write counts only while the base is still unassigned.
    always_comb begin
        port_wr_open = (kind == ACC_WR_PORT) && !base_assigned;
        load_base    = port_wr_open && (port_run == CNT_LAST);
    end

    // Track the run of port writes and latch the assigned flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_run      <= '0;
            base_assigned <= 1'b0;
        end else if (kind != ACC_IDLE) begin
            if (port_wr_open) begin
                port_run <= load_base ? '0 : port_run + CNT_W'(1);
            end else begin
                port_run <= '0;
            end
            if (load_base) begin
                base_assigned <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cfg_reg_bank.sv
// Holds registers A, B and C and applies gated writes and the base load.
// Assumes the unlock flags and the base load come from the same cycle's access.
module cfg_reg_bank
    import cfg_gate_pkg::*;
#(
    parameter logic [7:0] RST_A = 8'h00,
    parameter logic [7:0] RST_B = 8'h00,
    parameter logic [7:0] RST_C = 8'h20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  acc_kind_e  kind,
    input  logic [7:0] wdata,
    input  logic       ok_a,
    input  logic       ok_b,
    input  logic       ok_c,
    input  logic       load_base,
    output logic [7:0] cfg_a,
    output logic [7:0] cfg_b,
    output logic [7:0] cfg_c
);

    logic sw_open;
    logic take_a;
    logic take_b;
    logic take_c;

    // Decide which register, if any, accepts this cycle's write.
    always_comb begin
        sw_open = !cfg_c[LOCK_BIT];
        take_a  = sw_open && ok_a && (kind == ACC_WR_A);
        take_b  = sw_open && ok_b && (kind == ACC_WR_B);
        take_c  = sw_open && ok_c && (kind == ACC_WR_C);
    end

    // Register A: software write or low-field load from the port path.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_a <= fix_a(RST_A);
        end else if (take_a) begin
            cfg_a <= fix_a(wdata);
        end else if (load_base) begin
            cfg_a <= fix_a({cfg_a[REG_W-1:BASE_W], wdata[BASE_W-1:0]});
        end
    end

    // Register B: software write only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_b <= fix_b(RST_B);
        end else if (take_b) begin
            cfg_b <= fix_b(wdata);
        end
    end

    // Register C: software write only; its top bit closes software access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_c <= fix_c(RST_C);
        end else if (take_c) begin
            cfg_c <= fix_c(wdata);
        end
    end

endmodule

// File: rtl/cfg_access_gate.sv
// Top of the configuration access gate: classifies host accesses, tracks the
// unlock history and the port-write run, and holds the three registers.
// Assumes one-cycle strobes and a synchronous active-low reset.
module cfg_access_gate
    import cfg_gate_pkg::*;
#(
    parameter int unsigned ADDR_W         = 10,
    parameter int unsigned ADDR_A         = 'h300,
    parameter int unsigned ADDR_B         = 'h301,
    parameter int unsigned ADDR_C         = 'h302,
    parameter int unsigned PORT_ADDR      = 'h278,
    parameter int unsigned C_UNLOCK_READS = 3,
    parameter int unsigned JL_WRITES      = 4,
    parameter logic [7:0]  RST_A          = 8'h00,
    parameter logic [7:0]  RST_B          = 8'h00,
    parameter logic [7:0]  RST_C          = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic              page_sel,
    output logic [7:0]        rdata,
    output logic [7:0]        cfg_a,
    output logic [7:0]        cfg_b,
    output logic [7:0]        cfg_c,
    output logic              base_assigned
);

    acc_kind_e kind;
    logic      trk_ok_a;
    logic      trk_ok_b;
    logic      trk_ok_c;
    logic      load_base;

    cfg_acc_decode #(
        .ADDR_W    (ADDR_W),
        .ADDR_A    (ADDR_A),
        .ADDR_B    (ADDR_B),
        .ADDR_C    (ADDR_C),
        .PORT_ADDR (PORT_ADDR)
    ) u_dec (
        .io_addr  (io_addr),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .page_sel (page_sel),
        .kind     (kind)
    );

    cfg_unlock_track #(
        .C_UNLOCK_READS (C_UNLOCK_READS)
    ) u_trk (
        .clk   (clk),
        .rst_n (rst_n),
        .kind  (kind),
        .ok_a  (trk_ok_a),
        .ok_b  (trk_ok_b),
        .ok_c  (trk_ok_c)
    );

    cfg_base_assign #(
        .JL_WRITES (JL_WRITES)
    ) u_base (
        .clk           (clk),
        .rst_n         (rst_n),
        .kind          (kind),
        .load_base     (load_base),
        .base_assigned (base_assigned)
    );

    cfg_reg_bank #(
        .RST_A (RST_A),
        .RST_B (RST_B),
        .RST_C (RST_C)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .wdata     (io_wdata),
        .ok_a      (trk_ok_a),
        .ok_b      (trk_ok_b),
        .ok_c      (trk_ok_c),
        .load_base (load_base),
        .cfg_a     (cfg_a),
        .cfg_b     (cfg_b),
        .cfg_c     (cfg_c)
    );

    // Read data mux: the addressed register during its read, zero otherwise.
    always_comb begin
        case (kind)
            ACC_RD_A: rdata = cfg_a;
            ACC_RD_B: rdata = cfg_b;
            ACC_RD_C: rdata = cfg_c;
            default:  rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfg_access_gate_chk.sv
// Property checker for the configuration access gate, bound to the top.
// Assumes it observes the top's ports and the tracker/base-path nets.
module cfg_access_gate_chk #(
    parameter int unsigned ADDR_W    = 10,
    parameter int unsigned ADDR_A    = 'h300,
    parameter int unsigned ADDR_B    = 'h301,
    parameter int unsigned ADDR_C    = 'h302,
    parameter int unsigned PORT_ADDR = 'h278
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_rd,
    input logic              io_wr,
    input logic              page_sel,
    input logic [7:0]        rdata,
    input logic [7:0]        cfg_a,
    input logic [7:0]        cfg_b,
    input logic [7:0]        cfg_c,
    input logic              base_assigned,
    input logic              trk_ok_a,
    input logic              trk_ok_b,
    input logic              trk_ok_c
);

    logic wr_only;
    logic wr_a_hit;
    logic wr_b_hit;
    logic wr_c_hit;
    logic port_wr;

    // Port-level view of the write being made this cycle.
    always_comb begin
        wr_only  = io_wr && !io_rd;
        wr_a_hit = wr_only && page_sel && (io_addr == ADDR_W'(ADDR_A));
        wr_b_hit = wr_only && page_sel && (io_addr == ADDR_W'(ADDR_B));
        wr_c_hit = wr_only && page_sel && (io_addr == ADDR_W'(ADDR_C));
        port_wr  = wr_only && (io_addr == ADDR_W'(PORT_ADDR));
    end

    a_r1_a_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_a_hit && !trk_ok_a |=> $stable(cfg_a))
        else $error("a_r1_a_needs_read");

    a_r2_b_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
        wr_b_hit && !trk_ok_b |=> $stable(cfg_b))
        else $error("a_r2_b_needs_read");

    a_r3_c_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        wr_c_hit && !trk_ok_c |=> $stable(cfg_c))
        else $error("a_r3_c_needs_run");

    a_r4_sw_disable: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a_hit || wr_b_hit || wr_c_hit) && cfg_c[7]
        |=> $stable(cfg_a) && $stable(cfg_b) && $stable(cfg_c))
        else $error("a_r4_sw_disable");

    a_r6_base_from_port: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(base_assigned) |-> $past(port_wr))
        else $error("a_r6_base_from_port");

    a_r7_base_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        base_assigned |=> base_assigned)
        else $error("a_r7_base_sticky");

    a_r7_port_closed: assert property (@(posedge clk) disable iff (!rst_n)
        base_assigned && port_wr |=> $stable(cfg_a))
        else $error("a_r7_port_closed");

    a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_a[7] && !cfg_b[4] && (cfg_c[6:4] == 3'b010))
        else $error("a_r8_reserved");

    a_r10_rdata_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |-> (rdata == 8'h00))
        else $error("a_r10_rdata_quiet");

    a_r11_read_wins: assert property (@(posedge clk) disable iff (!rst_n)
        io_rd && io_wr |=> $stable(cfg_a) && $stable(cfg_b) && $stable(cfg_c))
        else $error("a_r11_read_wins");

endmodule

bind cfg_access_gate cfg_access_gate_chk #(
    .ADDR_W    (ADDR_W),
    .ADDR_A    (ADDR_A),
    .ADDR_B    (ADDR_B),
    .ADDR_C    (ADDR_C),
    .PORT_ADDR (PORT_ADDR)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .io_addr       (io_addr),
    .io_rd         (io_rd),
    .io_wr         (io_wr),
    .page_sel      (page_sel),
    .rdata         (rdata),
    .cfg_a         (cfg_a),
    .cfg_b         (cfg_b),
    .cfg_c         (cfg_c),
    .base_assigned (base_assigned),
    .trk_ok_a      (trk_ok_a),
    .trk_ok_b      (trk_ok_b),
    .trk_ok_c      (trk_ok_c)
);

// File: tb/sim_cfg_access_gate.sv
`timescale 1ns/1ps
module sim_cfg_access_gate;

    localparam int unsigned AW    = 10;
    localparam logic [9:0]  A_AD  = 10'h300;
    localparam logic [9:0]  B_AD  = 10'h301;
    localparam logic [9:0]  C_AD  = 10'h302;
    localparam logic [9:0]  P_AD  = 10'h278;
    localparam int unsigned NRUN  = 3;
    localparam int unsigned NPORT = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] io_addr = '0;
    logic [7:0]    io_wdata = '0;
    logic          io_rd = 1'b0;
    logic          io_wr = 1'b0;
    logic          page_sel = 1'b0;
    logic [7:0]    rdata;
    logic [7:0]    cfg_a;
    logic [7:0]    cfg_b;
    logic [7:0]    cfg_c;
    logic          base_assigned;

    int checks = 0;
    int errors = 0;

    // Reference state computed from the requirements.
    logic [7:0] m_a, m_b, m_c;
    logic       m_base;
    int         m_run;
    logic       m_lastb;
    int         m_port;

    always #2.5 clk = ~clk;

    cfg_access_gate #(
        .ADDR_W (AW), .ADDR_A ('h300), .ADDR_B ('h301), .ADDR_C ('h302),
        .PORT_ADDR ('h278), .C_UNLOCK_READS (NRUN), .JL_WRITES (NPORT),
        .RST_A (8'h00), .RST_B (8'h00), .RST_C (8'h20)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .io_addr (io_addr), .io_wdata (io_wdata),
        .io_rd (io_rd), .io_wr (io_wr), .page_sel (page_sel), .rdata (rdata),
        .cfg_a (cfg_a), .cfg_b (cfg_b), .cfg_c (cfg_c),
        .base_assigned (base_assigned)
    );

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check8({tag, " R1 cfg_a"}, cfg_a, m_a);
        check8({tag, " R2 cfg_b"}, cfg_b, m_b);
        check8({tag, " R3 cfg_c"}, cfg_c, m_c);
        check8({tag, " R6 base"}, {7'd0, base_assigned}, {7'd0, m_base});
    endtask

    // Reference model of reserved-bit forcing (R8).
    function automatic logic [7:0] ex_c(input logic [7:0] d);
        return (d & 8'h8F) | 8'h20;
    endfunction

    task automatic model_reset();
        m_a = 8'h00; m_b = 8'h00; m_c = 8'h20; m_base = 1'b0;
        m_run = 0; m_lastb = 1'b0; m_port = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; io_rd = 1'b0; io_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check_all("R9 reset");
    endtask

    // Update the reference model for one access.
    task automatic model_step(input logic rd, input logic wr, input logic [9:0] ad,
                              input logic [7:0] d, input logic pg);
        logic is_rd, is_wr, ha, hb, hc, hp, open;
        is_rd = rd;
        is_wr = wr && !rd;
        ha = pg && ad == A_AD;
        hb = pg && ad == B_AD;
        hc = pg && ad == C_AD;
        hp = ad == P_AD;
        open = !m_c[7];
        if (is_wr && ha && m_run > 0 && open)          m_a = d & 8'h7F;
        if (is_wr && hb && m_lastb && open)            m_b = d & 8'hEF;
        if (is_wr && hc && m_run >= int'(NRUN) && open) m_c = ex_c(d);
        if (is_wr && hp && !ha && !hb && !hc && !m_base) begin
            m_port++;
            if (m_port == int'(NPORT)) begin
                m_a = {m_a[7:3], d[2:0]};
                m_base = 1'b1;
                m_port = 0;
            end
        end else if (is_rd || is_wr) begin
            m_port = 0;
        end
        if (is_rd && ha) begin
            m_run = (m_run < int'(NRUN)) ? m_run + 1 : m_run;
            m_lastb = 1'b0;
        end else if (is_rd && hb) begin
            m_run = 0; m_lastb = 1'b1;
        end else if (is_rd || is_wr) begin
            m_run = 0; m_lastb = 1'b0;
        end
    endtask

    // One host access: drive at the falling edge, check read data, then state.
    task automatic access(input string tag, input logic rd, input logic wr,
                          input logic [9:0] ad, input logic [7:0] d, input logic pg);
        logic [7:0] exp_rd;
        @(negedge clk);
        io_rd = rd; io_wr = wr; io_addr = ad; io_wdata = d; page_sel = pg;
        exp_rd = 8'h00;
        if (rd && pg && ad == A_AD) exp_rd = m_a;
        else if (rd && pg && ad == B_AD) exp_rd = m_b;
        else if (rd && pg && ad == C_AD) exp_rd = m_c;
        #1;
        check8({tag, " R10 rdata"}, rdata, exp_rd);
        @(posedge clk);
        #1;
        io_rd = 1'b0; io_wr = 1'b0;
        model_step(rd, wr, ad, d, pg);
        check_all(tag);
    endtask

    task automatic rd_(input string t, input logic [9:0] ad); access(t, 1, 0, ad, 8'h00, 1); endtask
    task automatic wr_(input string t, input logic [9:0] ad, input logic [7:0] d); access(t, 0, 1, ad, d, 1); endtask

    initial begin : watchdog
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd2024));
        model_reset();
        do_reset();

        // R1: write without a prior read of A is dropped.
        wr_("R1 no read", A_AD, 8'h55);
        check8("R1 dropped", cfg_a, 8'h00);
        rd_("R1 read A", A_AD);
        wr_("R1 unlocked", A_AD, 8'hFF);
        check8("R8 A bit7", cfg_a, 8'h7F);
        // R1: idle cycles do not break the history.
        rd_("R1 read A", A_AD);
        repeat (3) @(negedge clk);
        wr_("R1 after idle", A_AD, 8'h12);
        check8("R1 idle kept", cfg_a, 8'h12);
        // R2 and R8 on B.
        rd_("R2 read B", B_AD);
        wr_("R2 unlocked", B_AD, 8'hFF);
        check8("R8 B bit4", cfg_b, 8'hEF);
        wr_("R2 second write", B_AD, 8'h00);
        check8("R5 history cleared by write", cfg_b, 8'hEF);
        // R5: a read of B between breaks the A unlock.
        rd_("R5 read A", A_AD);
        rd_("R5 read B", B_AD);
        wr_("R5 broken", A_AD, 8'h34);
        check8("R5 A kept", cfg_a, 8'h12);
        // R3: two reads are not enough, three are.
        rd_("R3 r1", A_AD); rd_("R3 r2", A_AD);
        wr_("R3 short", C_AD, 8'h0F);
        check8("R3 short run", cfg_c, 8'h20);
        rd_("R3 r1", A_AD); rd_("R3 r2", A_AD); rd_("R3 r3", A_AD);
        wr_("R3 full", C_AD, 8'h7F);
        check8("R3 C written", cfg_c, 8'h2F);
        // R11: both strobes is a read of A, which then unlocks A.
        access("R11 both", 1, 1, A_AD, 8'h66, 1);
        check8("R11 no write", cfg_a, 8'h12);
        wr_("R11 follow", A_AD, 8'h21);
        // R10: page deselected reads return zero and break history.
        rd_("R10 r1", A_AD);
        access("R10 page off", 1, 0, A_AD, 8'h00, 0);
        wr_("R10 broken", A_AD, 8'h44);
        check8("R10 A kept", cfg_a, 8'h21);
        // R4: lock bit set, software writes dropped.
        rd_("R4 r1", A_AD); rd_("R4 r2", A_AD); rd_("R4 r3", A_AD);
        wr_("R4 lock", C_AD, 8'h80);
        check8("R4 C locked", cfg_c, 8'hA0);
        rd_("R4 read A", A_AD);
        wr_("R4 blocked", A_AD, 8'h11);
        check8("R4 A kept", cfg_a, 8'h21);
        // R6: three port writes, interruption, then four.
        wr_("R6 p1", P_AD, 8'h03); wr_("R6 p2", P_AD, 8'h03); wr_("R6 p3", P_AD, 8'h03);
        rd_("R6 break", 10'h100);
        wr_("R6 p1", P_AD, 8'h05); wr_("R6 p2", P_AD, 8'h05); wr_("R6 p3", P_AD, 8'h05);
        check8("R6 not yet", {7'd0, base_assigned}, 8'h00);
        wr_("R6 p4", P_AD, 8'hFD);
        check8("R6 base loaded", cfg_a, 8'h25);
        check8("R6 flag", {7'd0, base_assigned}, 8'h01);
        // R7: further port writes do nothing.
        for (int i = 0; i < 5; i++) wr_("R7 closed", P_AD, 8'h02);
        check8("R7 A kept", cfg_a, 8'h25);

        // Random mix with periodic resets.
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            int sel;
            logic [9:0] ad;
            logic [7:0] d;
            logic rd, wr, pg;
            sel = int'($urandom % 10);
            case (sel)
                0, 1, 2: ad = A_AD;
                3:       ad = B_AD;
                4:       ad = C_AD;
                5, 6, 7: ad = P_AD;
                default: ad = 10'h100 + 10'($urandom % 16);
            endcase
            pg = ($urandom % 8) != 0;
            rd = ($urandom % 2) == 0;
            wr = !rd || (($urandom % 16) == 0);
            d  = 8'($urandom);
            d[7] = (($urandom % 16) == 0);
            if (ad == P_AD && !rd) access("RND port", rd, wr, ad, d, pg);
            else access("RND", rd, wr, ad, d, pg);
            if ((n % 400) == 399) do_reset();
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule